// File: doc/BRIEF.md
# Stopwatch and Periodic Interrupt Timer

This block keeps time for a pair of processors that share one clock domain. A prescaler divides the clock by DIV (384 by default) to form a base tick. Two timers count that tick. The first is a 12-bit stopwatch that runs freely and wraps. Either processor can read it, and the secondary processor clears it. The second is an 8-bit interval timer. It requests the level-3 interrupt every N base ticks after a nonzero N is written to it.

Software reaches both timers through one small register port. `reg_sel` picks the stopwatch (0) or the interval register (1). `reg_be` holds byte-lane enables, bit 0 for data bits 7:0 and bit 1 for bits 15:8. Read data appears combinationally on `reg_rdata`. The primary processor's view of the stopwatch is driven permanently on `pri_watch_q`.

The interrupt side has three pins: an enable input, a request output and an acknowledge input. All of them are plain level pins with no handshake. Each timer owns its own divide-by-DIV phase counter. Clearing the stopwatch therefore has no effect on when the interval timer expires, and writing the interval register has no effect on the stopwatch.

Top module: `cd_tick_timers`

## Requirements
- R1: The stopwatch reads floor(c / DIV) mod 4096, where c is the number of clock edges since the last clear or reset. Its first increment comes a full DIV cycles after a clear.
- R2: A write with `reg_sel`=0 and either bit of `reg_be` set clears the stopwatch and restarts its prescaler. The write data has no effect on the result.
- R3: With `reg_sel`=0, `reg_rdata` equals {4'b0, stopwatch}, and `pri_watch_q` carries the same value in every cycle.
- R4: The interval value N is written with `reg_sel`=1 and `reg_be[0]`=1, from `reg_wdata[7:0]`. It reads back as {8'b0, N}. An interval write with `reg_be[0]`=0 changes nothing.
- R5: After a nonzero N is written, the interval timer expires exactly N*DIV cycles later. It then keeps expiring every N*DIV cycles until the register is written again, and each write restarts the phase.
- R6: An expiry while `irq_en`=1 sets `irq_req`. The request stays high until `irq_ack`, and a new expiry in the same cycle as an acknowledge wins.
- R7: An expiry while `irq_en`=0 leaves `irq_req` unchanged.
- R8: Writing N=0 stops all further expiries and drops `irq_req` in the next cycle.
- R9: After reset, the stopwatch, the interval register and `irq_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | 0 = stopwatch, 1 = interval register |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte-lane enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| pri_watch_q | output | 16 | Primary processor's stopwatch view |
| irq_en | input | 1 | Level-3 interrupt enable |
| irq_ack | input | 1 | Clears the interrupt request |
| irq_req | output | 1 | Level-3 interrupt request |

## Verification
The bench compares every cycle against a reference model that counts elapsed cycles. The first target is the first increment after a clear: a design that kept the old prescaler phase would step early. The second is the 4095-to-0 wrap: a design that saturated, or dropped bits, would read wrong values there. The bench also goes after four interrupt corner cases:
- an expiry that lands on the same edge as an acknowledge, which a design that put acknowledge first would lose;
- an expiry while the enable is low, which a design that latched it for later would raise;
- writing zero while a request is pending, which a design that only stopped the counter would leave high;
- an interval write with only the high byte lane enabled, which a sloppy decoder would accept.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  typedef enum logic {
    SEL_WATCH = 1'b0,
    SEL_IVL   = 1'b1
  } ctt_sel_e;

  localparam int unsigned REG_W = 16;
endpackage

// File: rtl/ctt_divider.sv
module ctt_divider #(
  parameter int unsigned DIV = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] phase;
  logic          at_end;

  assign at_end = (phase == CW'(DIV - 1));
  assign tick   = at_end && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)                 phase <= '0;
    else if (restart || at_end) phase <= '0;
    else                        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ctt_stopwatch.sv
module ctt_stopwatch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) count_q <= '0;
    else if (tick)     count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/ctt_interval.sv
module ctt_interval #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         tick,
  output logic [W-1:0] period_q,
  output logic         expire
);
  logic [W-1:0] remain;
  logic         armed;
  logic         last;

  assign armed  = (period_q != '0);
  assign last   = (remain == W'(1));
  assign expire = tick && armed && last && !wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      remain   <= '0;
    end else if (wr) begin
      period_q <= wdata;
      remain   <= wdata;
    end else if (tick && armed) begin
      remain <= last ? period_q : remain - 1'b1;
    end
  end
endmodule

// File: rtl/ctt_irq_latch.sv
module ctt_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cancel,
  input  logic set,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk) begin
    if (!rst_n)      req <= 1'b0;
    else if (cancel) req <= 1'b0;
    else if (set)    req <= 1'b1;
    else if (ack)    req <= 1'b0;
  end
endmodule

// File: rtl/cd_tick_timers.sv
module cd_tick_timers #(
  parameter int unsigned DIV   = 384,
  parameter int unsigned SW_W  = 12,
  parameter int unsigned IVL_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [15:0] pri_watch_q,
  input  logic        irq_en,
  input  logic        irq_ack,
  output logic        irq_req
);
  import ctt_pkg::*;

  ctt_sel_e         sel;
  logic             watch_clr;
  logic             ivl_wr;
  logic             ivl_cancel;
  logic [SW_W-1:0]  watch;
  logic [IVL_W-1:0] period;
  logic             expire;
  logic [1:0]       tick;
  logic [1:0]       restart;

  assign sel        = ctt_sel_e'(reg_sel);
  assign watch_clr  = reg_wr && (sel == SEL_WATCH) && (reg_be != 2'b00);
  assign ivl_wr     = reg_wr && (sel == SEL_IVL) && reg_be[0];
  assign ivl_cancel = ivl_wr && (reg_wdata[IVL_W-1:0] == '0);
  assign restart    = {ivl_wr, watch_clr};

  for (genvar g = 0; g < 2; g++) begin : g_div
    ctt_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .restart(restart[g]), .tick(tick[g])
    );
  end

  ctt_stopwatch #(.W(SW_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .clr(watch_clr), .tick(tick[0]), .count_q(watch)
  );

  ctt_interval #(.W(IVL_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .wr(ivl_wr), .wdata(reg_wdata[IVL_W-1:0]),
    .tick(tick[1]), .period_q(period), .expire(expire)
  );

  ctt_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .cancel(ivl_cancel),
    .set(expire && irq_en), .ack(irq_ack), .req(irq_req)
  );

  assign pri_watch_q = REG_W'(watch);

  always_comb begin
    case (sel)
      SEL_WATCH: reg_rdata = REG_W'(watch);
      default:   reg_rdata = REG_W'(period);
    endcase
  end
endmodule

// File: rtl/cd_tick_timers_chk.sv
module cd_tick_timers_chk #(
  parameter int unsigned SW_W = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic        reg_wr,
  input logic [1:0]  reg_be,
  input logic [15:0] reg_wdata,
  input logic [15:0] reg_rdata,
  input logic [15:0] pri_watch_q,
  input logic        irq_en,
  input logic        irq_ack,
  input logic        irq_req
);
  logic            clr_seen;
  logic            zero_ivl;
  logic [SW_W-1:0] w;

  assign clr_seen = reg_wr && !reg_sel && (reg_be != 2'b00);
  assign zero_ivl = reg_wr && reg_sel && reg_be[0] && (reg_wdata[7:0] == 8'h00);
  assign w        = pri_watch_q[SW_W-1:0];

  a_r1_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_seen |=> (w == $past(w)) || (w == $past(w) + 1'b1));

  a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_seen |=> (w == '0));

  a_r3_views_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata == pri_watch_q) && (pri_watch_q[15:SW_W] == '0));

  a_r4_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[15:8] == 8'h00));

  a_r6_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack && !zero_ivl |=> irq_req);

  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(irq_en));

  a_r8_zero_drops: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ivl |=> !irq_req);
endmodule

bind cd_tick_timers cd_tick_timers_chk #(.SW_W(SW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .pri_watch_q(pri_watch_q), .irq_en(irq_en), .irq_ack(irq_ack),
  .irq_req(irq_req)
);

// File: tb/sim_cd_tick_timers.sv
`timescale 1ns/1ps
module sim_cd_tick_timers;
  localparam int DIV = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [15:0] pri_watch_q;
  logic        irq_en = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  longint m_sw_cyc = 0;
  longint m_ivl_cyc = 0;
  int     m_n = 0;
  bit     m_irq = 0;

  always #2.5 clk = ~clk;

  cd_tick_timers #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pri_watch_q(pri_watch_q), .irq_en(irq_en), .irq_ack(irq_ack),
    .irq_req(irq_req)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic int exp_sw();
    return int'((m_sw_cyc / DIV) % 4096);
  endfunction

  task automatic model_edge();
    bit fire;
    bit cancel;
    fire = 0;
    cancel = 0;
    if (!rst_n) begin
      m_sw_cyc = 0; m_ivl_cyc = 0; m_n = 0; m_irq = 0;
    end else begin
      if (reg_wr && !reg_sel && reg_be != 2'b00) m_sw_cyc = 0;
      else m_sw_cyc++;
      if (reg_wr && reg_sel && reg_be[0]) begin
        m_n = int'(reg_wdata[7:0]);
        m_ivl_cyc = 0;
        cancel = (m_n == 0);
      end else begin
        m_ivl_cyc++;
        fire = (m_n != 0) && (m_ivl_cyc % (m_n * DIV) == 0);
      end
      if (cancel) m_irq = 0;
      else if (fire && irq_en) m_irq = 1;
      else if (irq_ack) m_irq = 0;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 stopwatch", pri_watch_q, exp_sw());
    chk("R6 irq_req", irq_req, m_irq);
    if (!reg_sel) chk("R3 rdata watch view", reg_rdata, exp_sw());
    else          chk("R4 rdata interval", reg_rdata, m_n);
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  task automatic wr1(input bit sel, input logic [1:0] be, input logic [15:0] d);
    reg_sel = sel; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_be = 2'b00;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    steps(3);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 watch after reset", pri_watch_q, 0);
    chk("R9 irq after reset", irq_req, 0);
    reg_sel = 1'b1; #0.1;
    chk("R9 interval after reset", reg_rdata, 0);
    reg_sel = 1'b0;

    steps(30);
    chk("R1 watch at 30 cycles", pri_watch_q, 30 / DIV);

    // R2: high-lane-only clear with junk data
    steps(3);
    wr1(1'b0, 2'b10, 16'hFFFF);
    chk("R2 cleared", pri_watch_q, 0);
    steps(DIV - 1);
    chk("R1 no early step", pri_watch_q, 0);
    step();
    chk("R1 first step", pri_watch_q, 1);

    // R4 interval write and lane rules
    wr1(1'b1, 2'b01, 16'hAB03);
    chk("R4 readback", reg_rdata, 3);
    wr1(1'b1, 2'b10, 16'h5555);
    chk("R4 high lane ignored", reg_rdata, 3);

    // R5 / R6: exact expiry time with enable on
    irq_en = 1'b1;
    wr1(1'b1, 2'b01, 16'h0003);
    steps(3 * DIV - 1);
    chk("R5 not yet expired", irq_req, 0);
    step();
    chk("R5 expiry at N*DIV", irq_req, 1);
    steps(40);
    chk("R6 held without ack", irq_req, 1);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    chk("R6 acked", irq_req, 0);

    // R7: expiries with enable off
    irq_en = 1'b0;
    steps(8 * DIV);
    chk("R7 no irq while disabled", irq_req, 0);

    // R8: zero write drops pending request and stops timer
    irq_en = 1'b1;
    steps(3 * DIV);
    chk("R6 raised again", irq_req, 1);
    wr1(1'b1, 2'b01, 16'hFF00);
    chk("R8 request dropped", irq_req, 0);
    steps(10 * DIV);
    chk("R8 no further expiry", irq_req, 0);

    // R1 wrap
    reg_sel = 1'b0;
    wr1(1'b0, 2'b01, 16'h1234);
    steps(4096 * DIV - 1);
    chk("R1 top value", pri_watch_q, 4095);
    step();
    chk("R1 wrap to zero", pri_watch_q, 0);

    // mixed stimulus, compared every cycle against the model
    r = 32'h1ACE_B00C;
    for (int i = 0; i < 6000; i++) begin
      r = r * 32'd1103515245 + 32'd12345;
      irq_ack = (r[20:18] == 3'd0);
      if (r[27:24] == 4'd0) irq_en = ~irq_en;
      reg_sel = r[28];
      if (r[15:10] == 6'd0) begin
        reg_wr = 1'b1;
        reg_be = r[1:0];
        reg_wdata = {8'h5A, 6'd0, r[4:3]};
      end else begin
        reg_wr = 1'b0;
        reg_be = 2'b00;
      end
      step();
    end
    reg_wr = 1'b0; irq_ack = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule